// File: doc/BRIEF.md
# Free-Hole Memory Allocator

This block manages a pool of memory words as a small table of free holes. Each hole is described by a start address and a length. An allocation request names a size and a placement policy. The block searches the table one entry per clock and grants a region of the requested size from the hole that the policy picks. It answers with the start address of the region, or with a failure flag when no hole is large enough.

A release request hands a region back to the pool. When the returned region touches one or two existing holes, the block folds them into a single larger hole. Otherwise the region takes an empty table slot. A release that overlaps a free hole, has zero size, or finds no slot is refused with an error flag, and the table is left unchanged. Requests enter through a valid/ready handshake and results leave through a second valid/ready handshake. Only one request is in flight at any time.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds exactly one hole, starting at address 0 and covering MEM_WORDS words, with the next-fit pointer at entry 0. `req_ready` is high and `rsp_valid` is low.
- R2: Under first fit (`req_policy`=0), the block grants the valid entry with the lowest index whose length is at least the requested size.
- R3: Under next fit (`req_policy`=1), the scan starts at the index of the most recently granted entry (granted under any policy) and wraps modulo ENTRIES. The first large-enough entry in that order is granted.
- R4: Under best fit (`req_policy`=2), the block grants the smallest large-enough hole. Among equal lengths, the lowest index wins.
- R5: Under worst fit (`req_policy`=3), the block grants the largest hole, provided it is large enough. Among equal lengths, the lowest index wins.
- R6: A grant takes the low end of the chosen hole. `rsp_addr` is the old start of the hole. The hole's start then moves up by the size and its length drops by the size, and a hole whose length reaches zero is removed.
- R7: An allocation of size zero, or one that no hole can satisfy, answers with `rsp_fail`=1 and `rsp_addr`=0, and leaves the table unchanged. An allocation never raises `rsp_err`.
- R8: A release (`req_op`=1, region `req_addr`, `req_size`) is handled as follows:
  - When a hole ends at `req_addr` and another hole starts at `req_addr+req_size`, the two holes and the region become one hole in the lower hole's slot, and the upper hole's slot is emptied.
  - When only one such neighbour exists, the region is merged into that neighbour.
  - When neither exists, the region goes into the lowest-index empty slot.
- R9: A release of size zero, one that overlaps a free hole, or one that has no neighbour and finds no empty slot answers with `rsp_err`=1. It leaves the table unchanged and never raises `rsp_fail`.
- R10: `req_ready` is high only while no request is in flight. The response stays valid and stable until `rsp_ready`. `rsp_valid` rises at most 17 clock cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_policy | input | 2 | Placement policy: 0 first, 1 next, 2 best, 3 worst |
| req_addr | input | ADDR_W | Start of the region being released |
| req_size | input | ADDR_W+1 | Size in words |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | ADDR_W | Granted start address, 0 otherwise |
| rsp_fail | output | 1 | Allocation could not be satisfied |
| rsp_err | output | 1 | Release was refused |

## Verification
The bench compares every response against an arithmetic model of the hole table, built from the requirements. The directed patterns cover the following:
- Holes are carved so that each policy picks a different entry. This separates first fit from best and worst fit by size, and next fit from first fit by where the scan starts.
- Equal-length holes expose the lowest-index tie rule.
- Releases are placed beside a lower hole, beside an upper hole, between two holes, and in isolation, so that each merge path leaves a distinct hole that a later grant reveals.
- A table filled with sixteen separated holes, together with overlapping and zero-size releases, shows the refusals and that they leave the table unchanged.

A long pseudo-random sequence of mixed policies and releases then sweeps the table through many fragmentation states.

// File: rtl/hole_pkg.sv
// Shared encodings for the free-hole allocator.
package hole_pkg;
    typedef enum logic [1:0] {
        POL_FIRST = 2'd0,
        POL_NEXT  = 2'd1,
        POL_BEST  = 2'd2,
        POL_WORST = 2'd3
    } policy_e;

    typedef enum logic {
        OP_ALLOC   = 1'b0,
        OP_RELEASE = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_RESP   = 2'd3
    } state_e;
endpackage

// File: rtl/hole_table.sv
// hole_table: register file of free holes (valid, start, length).
// One combinational read port serves the scan. Write port A rewrites a
// whole entry. Port B only empties an entry.
// Assumes: ENTRIES is a power of two; A and B never target the same index
// in one cycle. Reset leaves a single hole [0, MEM_WORDS) in entry 0.
module hole_table #(
    parameter int ENTRIES   = 16,
    parameter int ADDR_W    = 8,
    parameter int MEM_WORDS = 256,
    parameter int LEN_W     = ADDR_W + 1,
    parameter int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_start,
    output logic [LEN_W-1:0]  rd_len,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic              wa_valid,
    input  logic [ADDR_W-1:0] wa_start,
    input  logic [LEN_W-1:0]  wa_len,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx
);
    logic              tv [ENTRIES];
    logic [ADDR_W-1:0] ts [ENTRIES];
    logic [LEN_W-1:0]  tl [ENTRIES];

    // Purpose: reset the pool to one full hole, then apply commit writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tv[i] <= (i == 0);
                ts[i] <= '0;
                tl[i] <= (i == 0) ? LEN_W'(MEM_WORDS) : '0;
            end
        end else begin
            if (wa_en) begin
                tv[wa_idx] <= wa_valid;
                ts[wa_idx] <= wa_start;
                tl[wa_idx] <= wa_len;
            end
            if (wb_en) begin
                tv[wb_idx] <= 1'b0;
            end
        end
    end

    // Purpose: present the entry selected by the scan index.
    always_comb begin
        rd_valid = tv[rd_idx];
        rd_start = ts[rd_idx];
        rd_len   = tl[rd_idx];
    end
endmodule

// File: rtl/hole_scan.sv
// hole_scan: looks at one table entry per step and keeps running results:
// the placement candidate for the active policy, the lower and upper
// neighbours of a released region, any overlap, and the first empty slot.
// Assumes: the caller presents entries in its chosen scan order. For best
// and worst fit that order starts at index 0, so a strict compare keeps the
// lowest index on ties. clear restarts the search.
module hole_scan
    import hole_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = ADDR_W + 1,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [IDX_W-1:0]  e_idx,
    input  logic              e_valid,
    input  logic [ADDR_W-1:0] e_start,
    input  logic [LEN_W-1:0]  e_len,
    input  policy_e           policy,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [LEN_W-1:0]  size,
    output logic              fit_hit,
    output logic [IDX_W-1:0]  fit_idx,
    output logic [ADDR_W-1:0] fit_start,
    output logic [LEN_W-1:0]  fit_len,
    output logic              lo_hit,
    output logic [IDX_W-1:0]  lo_idx,
    output logic [ADDR_W-1:0] lo_start,
    output logic [LEN_W-1:0]  lo_len,
    output logic              hi_hit,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [LEN_W-1:0]  hi_len,
    output logic              ovl,
    output logic              emp_hit,
    output logic [IDX_W-1:0]  emp_idx
);
    localparam int END_W = LEN_W + 1;

    logic [END_W-1:0] e_end, r_end;
    logic fits, take_fit, lo_m, hi_m, ov_m, emp_m;

    // Purpose: compare the current entry with the request.
    always_comb begin
        e_end = END_W'(e_start) + END_W'(e_len);
        r_end = END_W'(rel_addr) + END_W'(size);
        fits  = e_valid && (e_len >= size);
        unique case (policy)
            POL_BEST:  take_fit = !fit_hit || (e_len < fit_len);
            POL_WORST: take_fit = !fit_hit || (e_len > fit_len);
            default:   take_fit = !fit_hit;
        endcase
        lo_m  = e_valid && (e_end == END_W'(rel_addr));
        hi_m  = e_valid && (END_W'(e_start) == r_end);
        ov_m  = e_valid && (END_W'(e_start) < r_end) && (END_W'(rel_addr) < e_end);
        emp_m = !e_valid && !emp_hit;
    end

    // Purpose: accumulate the search results across the scan.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fit_hit <= 1'b0; fit_idx <= '0; fit_start <= '0; fit_len <= '0;
            lo_hit  <= 1'b0; lo_idx  <= '0; lo_start  <= '0; lo_len  <= '0;
            hi_hit  <= 1'b0; hi_idx  <= '0; hi_len    <= '0;
            ovl     <= 1'b0; emp_hit <= 1'b0; emp_idx <= '0;
        end else if (step) begin
            if (fits && take_fit) begin
                fit_hit   <= 1'b1;
                fit_idx   <= e_idx;
                fit_start <= e_start;
                fit_len   <= e_len;
            end
            if (lo_m) begin
                lo_hit   <= 1'b1;
                lo_idx   <= e_idx;
                lo_start <= e_start;
                lo_len   <= e_len;
            end
            if (hi_m) begin
                hi_hit <= 1'b1;
                hi_idx <= e_idx;
                hi_len <= e_len;
            end
            if (ov_m) ovl <= 1'b1;
            if (emp_m) begin
                emp_hit <= 1'b1;
                emp_idx <= e_idx;
            end
        end
    end
endmodule

// File: rtl/hole_alloc.sv
// hole_alloc: top of the free-hole allocator. It accepts one request,
// scans all ENTRIES slots (one per cycle), commits the table update in one
// extra cycle, and then holds the response until it is taken.
// Assumes: ENTRIES is a power of two; released regions lie inside
// [0, MEM_WORDS) and were previously granted (not checked beyond overlap).
module hole_alloc
    import hole_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ENTRIES   = 16,
    parameter int MEM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [1:0]        req_policy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W:0]   req_size,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fail,
    output logic              rsp_err
);
    localparam int LEN_W = ADDR_W + 1;
    localparam int END_W = ADDR_W + 2;
    localparam int IDX_W = $clog2(ENTRIES);

    state_e            state;
    logic [IDX_W-1:0]  cnt, base_q, ptr_q, scan_idx;
    op_e               op_q;
    policy_e           pol_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  size_q;
    logic [ADDR_W-1:0] rsp_addr_q;
    logic              rsp_fail_q, rsp_err_q;
    logic              accept;

    logic              e_valid;
    logic [ADDR_W-1:0] e_start;
    logic [LEN_W-1:0]  e_len;

    logic              fit_hit, lo_hit, hi_hit, ovl, emp_hit;
    logic [IDX_W-1:0]  fit_idx, lo_idx, hi_idx, emp_idx;
    logic [ADDR_W-1:0] fit_start, lo_start;
    logic [LEN_W-1:0]  fit_len, lo_len, hi_len;

    logic              wa_en, wa_valid, wb_en;
    logic [IDX_W-1:0]  wa_idx, wb_idx;
    logic [ADDR_W-1:0] wa_start;
    logic [LEN_W-1:0]  wa_len;
    logic              cm_fail, cm_err, cm_grant;
    logic [ADDR_W-1:0] cm_addr;

    assign accept    = req_valid && (state == ST_IDLE);
    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_addr  = rsp_addr_q;
    assign rsp_fail  = rsp_fail_q;
    assign rsp_err   = rsp_err_q;
    assign scan_idx  = base_q + cnt;

    hole_table #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS),
        .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(scan_idx), .rd_valid(e_valid), .rd_start(e_start), .rd_len(e_len),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_valid(wa_valid),
        .wa_start(wa_start), .wa_len(wa_len),
        .wb_en(wb_en), .wb_idx(wb_idx)
    );

    hole_scan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .clear(accept), .step(state == ST_SCAN),
        .e_idx(scan_idx), .e_valid(e_valid), .e_start(e_start), .e_len(e_len),
        .policy(pol_q), .rel_addr(addr_q), .size(size_q),
        .fit_hit(fit_hit), .fit_idx(fit_idx), .fit_start(fit_start), .fit_len(fit_len),
        .lo_hit(lo_hit), .lo_idx(lo_idx), .lo_start(lo_start), .lo_len(lo_len),
        .hi_hit(hi_hit), .hi_idx(hi_idx), .hi_len(hi_len),
        .ovl(ovl), .emp_hit(emp_hit), .emp_idx(emp_idx)
    );

    // Purpose: turn the scan results into table writes and a response.
    always_comb begin
        wa_en = 1'b0; wa_idx = '0; wa_valid = 1'b0; wa_start = '0; wa_len = '0;
        wb_en = 1'b0; wb_idx = '0;
        cm_fail = 1'b0; cm_err = 1'b0; cm_grant = 1'b0; cm_addr = '0;
        if (state == ST_COMMIT) begin
            if (op_q == OP_ALLOC) begin
                if (size_q == '0 || !fit_hit) begin
                    cm_fail = 1'b1;
                end else begin
                    cm_grant = 1'b1;
                    cm_addr  = fit_start;
                    wa_en    = 1'b1;
                    wa_idx   = fit_idx;
                    wa_valid = (fit_len != size_q);
                    wa_start = ADDR_W'(END_W'(fit_start) + END_W'(size_q));
                    wa_len   = fit_len - size_q;
                end
            end else begin
                if (size_q == '0 || ovl) begin
                    cm_err = 1'b1;
                end else if (lo_hit && hi_hit) begin
                    wa_en = 1'b1; wa_idx = lo_idx; wa_valid = 1'b1;
                    wa_start = lo_start; wa_len = lo_len + size_q + hi_len;
                    wb_en = 1'b1; wb_idx = hi_idx;
                end else if (lo_hit) begin
                    wa_en = 1'b1; wa_idx = lo_idx; wa_valid = 1'b1;
                    wa_start = lo_start; wa_len = lo_len + size_q;
                end else if (hi_hit) begin
                    wa_en = 1'b1; wa_idx = hi_idx; wa_valid = 1'b1;
                    wa_start = addr_q; wa_len = size_q + hi_len;
                end else if (emp_hit) begin
                    wa_en = 1'b1; wa_idx = emp_idx; wa_valid = 1'b1;
                    wa_start = addr_q; wa_len = size_q;
                end else begin
                    cm_err = 1'b1;
                end
            end
        end
    end

    // Purpose: sequence accept, scan, commit and response hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            base_q     <= '0;
            ptr_q      <= '0;
            op_q       <= OP_ALLOC;
            pol_q      <= POL_FIRST;
            addr_q     <= '0;
            size_q     <= '0;
            rsp_addr_q <= '0;
            rsp_fail_q <= 1'b0;
            rsp_err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        pol_q  <= policy_e'(req_policy);
                        addr_q <= req_addr;
                        size_q <= req_size;
                        base_q <= (op_e'(req_op) == OP_ALLOC &&
                                   policy_e'(req_policy) == POL_NEXT) ? ptr_q : '0;
                        cnt    <= '0;
                        state  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == IDX_W'(ENTRIES - 1)) state <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    rsp_addr_q <= cm_addr;
                    rsp_fail_q <= cm_fail;
                    rsp_err_q  <= cm_err;
                    if (cm_grant) ptr_q <= fit_idx;
                    state <= ST_RESP;
                end
                default: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/hole_alloc_chk.sv
// hole_alloc_chk: protocol and outcome properties of hole_alloc, observed
// at its ports only. A counter measures the response latency window.
module hole_alloc_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_op,
    input logic [ADDR_W:0]   req_size,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_fail,
    input logic              rsp_err
);
    logic       pending, op_rel, zero_sz;
    logic [5:0] lat;

    // Purpose: remember the op in flight and count cycles to its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0; op_rel <= 1'b0; zero_sz <= 1'b0; lat <= '0;
        end else if (req_valid && req_ready) begin
            pending <= 1'b1; op_rel <= req_op; zero_sz <= (req_size == '0); lat <= '0;
        end else if (pending) begin
            if (rsp_valid) pending <= 1'b0;
            else if (lat != 6'h3f) lat <= lat + 1'b1;
        end
    end

    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) &&
                                    $stable(rsp_fail) && $stable(rsp_err));
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> lat <= 6'd17);
    assert_one_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));
    assert_alloc_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !op_rel |-> !rsp_err);
    assert_fail_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fail |-> rsp_addr == '0);
    assert_release_no_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && op_rel |-> !rsp_fail);
    assert_zero_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && zero_sz |-> (rsp_fail || rsp_err));
endmodule

bind hole_alloc hole_alloc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fail(rsp_fail),
    .rsp_err(rsp_err)
);

// File: tb/hole_alloc_test.sv
// Bench for hole_alloc: directed hole layouts and a pseudo-random sweep,
// each response compared with an arithmetic model of the hole table.
module hole_alloc_test;
    localparam int AW = 8;
    localparam int NE = 16;
    localparam int MW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [1:0]    req_policy = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [AW:0]   req_size = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [AW-1:0] rsp_addr;
    logic          rsp_fail, rsp_err;

    int n_chk = 0;
    int n_fail = 0;

    int mv [NE];
    int ms [NE];
    int ml [NE];
    int mptr;

    int ba [64];
    int bn [64];
    int bc;
    int unsigned lf = 32'h1234_5678;

    int ra, rf, re;

    always #5 clk = ~clk;

    hole_alloc #(.ADDR_W(AW), .ENTRIES(NE), .MEM_WORDS(MW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_policy(req_policy), .req_addr(req_addr),
        .req_size(req_size), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_fail(rsp_fail), .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd();
        lf ^= lf << 13;
        lf ^= lf >> 17;
        lf ^= lf << 5;
        return int'(lf & 32'h7fff_ffff);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NE; i++) begin
            mv[i] = 0; ms[i] = 0; ml[i] = 0;
        end
        mv[0] = 1; ml[0] = MW; mptr = 0;
    endfunction

    function automatic void model_alloc(input int pol, input int n,
                                        output int addr, output int fail);
        int base, found, i;
        addr = 0; fail = 0; found = -1;
        base = (pol == 1) ? mptr : 0;
        for (int k = 0; k < NE; k++) begin
            i = (base + k) % NE;
            if (mv[i] != 0 && ml[i] >= n) begin
                if (found < 0) found = i;
                else if (pol == 2 && ml[i] < ml[found]) found = i;
                else if (pol == 3 && ml[i] > ml[found]) found = i;
            end
        end
        if (n == 0 || found < 0) begin
            fail = 1;
        end else begin
            addr = ms[found];
            ms[found] += n;
            ml[found] -= n;
            if (ml[found] == 0) mv[found] = 0;
            mptr = found;
        end
    endfunction

    function automatic void model_free(input int a, input int n, output int err);
        int lo, hi, emp, ov;
        lo = -1; hi = -1; emp = -1; ov = 0; err = 0;
        for (int i = 0; i < NE; i++) begin
            if (mv[i] != 0) begin
                if (ms[i] + ml[i] == a) lo = i;
                if (ms[i] == a + n) hi = i;
                if (ms[i] < a + n && a < ms[i] + ml[i]) ov = 1;
            end else if (emp < 0) begin
                emp = i;
            end
        end
        if (n == 0 || ov != 0) err = 1;
        else if (lo >= 0 && hi >= 0) begin
            ml[lo] += n + ml[hi]; mv[hi] = 0;
        end else if (lo >= 0) ml[lo] += n;
        else if (hi >= 0) begin
            ms[hi] = a; ml[hi] += n;
        end else if (emp >= 0) begin
            mv[emp] = 1; ms[emp] = a; ml[emp] = n;
        end else err = 1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One request through both handshakes, compared with the model.
    task automatic run(input string tag, input int op, input int pol, input int a,
                       input int n, input int hold,
                       output int o_addr, output int o_fail, output int o_err);
        int lat, maddr, mfail, merr;
        @(negedge clk);
        req_valid = 1'b1; req_op = op[0]; req_policy = pol[1:0];
        req_addr = a[AW-1:0]; req_size = n[AW:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R10", "latency bound", (lat <= 17) ? 1 : 0, 1);
        o_addr = int'(rsp_addr); o_fail = int'(rsp_fail); o_err = int'(rsp_err);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R10", "response held", int'(rsp_valid), 1);
            chk("R10", "addr stable", int'(rsp_addr), o_addr);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10", "ready after response", int'(req_ready), 1);
        maddr = 0; mfail = 0; merr = 0;
        if (op == 0) model_alloc(pol, n, maddr, mfail);
        else model_free(a, n, merr);
        chk(tag, "rsp_fail", o_fail, mfail);
        chk(tag, "rsp_err", o_err, merr);
        chk(tag, "rsp_addr", o_addr, maddr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);

        // R1/R6: whole pool is one hole; taking it all removes the entry.
        run("R1", 0, 0, 0, 256, 0, ra, rf, re); chk("R1", "full grant", ra, 0);
        run("R6", 0, 0, 0, 1, 2, ra, rf, re);   chk("R6", "emptied hole gone", rf, 1);
        run("R8", 1, 0, 0, 256, 0, ra, rf, re);

        // R2/R6: consecutive first-fit grants come from the low end.
        run("R2", 0, 0, 0, 10, 0, ra, rf, re); chk("R2", "a0", ra, 0);
        run("R6", 0, 0, 0, 20, 0, ra, rf, re); chk("R6", "a1", ra, 10);
        run("R2", 0, 0, 0, 5, 0, ra, rf, re);  chk("R2", "a2", ra, 30);
        run("R2", 0, 0, 0, 40, 0, ra, rf, re); chk("R2", "a3", ra, 35);
        run("R2", 0, 0, 0, 3, 0, ra, rf, re);  chk("R2", "a4", ra, 75);
        run("R2", 0, 0, 0, 30, 0, ra, rf, re); chk("R2", "a5", ra, 78);
        run("R8", 1, 0, 10, 20, 0, ra, rf, re);
        run("R8", 1, 0, 35, 40, 0, ra, rf, re);
        run("R8", 1, 0, 78, 30, 0, ra, rf, re);  // merges with upper hole
        run("R4", 0, 2, 0, 15, 0, ra, rf, re); chk("R4", "best picks 20-hole", ra, 10);
        run("R2", 0, 0, 0, 4, 0, ra, rf, re);  chk("R2", "first picks slot 0", ra, 78);
        run("R5", 0, 3, 0, 30, 0, ra, rf, re); chk("R5", "worst picks largest", ra, 82);
        run("R4", 0, 2, 0, 38, 0, ra, rf, re); chk("R4", "best picks 40-hole", ra, 35);
        run("R3", 0, 1, 0, 2, 0, ra, rf, re);  chk("R3", "next resumes at slot 2", ra, 73);
        run("R3", 0, 1, 0, 3, 1, ra, rf, re);  chk("R3", "next wraps to slot 0", ra, 112);
        run("R8", 1, 0, 30, 5, 0, ra, rf, re);   // lower neighbour only
        run("R8", 1, 0, 75, 3, 0, ra, rf, re);   // isolated
        run("R9", 1, 0, 120, 4, 0, ra, rf, re); chk("R9", "overlap refused", re, 1);
        run("R9", 1, 0, 200, 0, 0, ra, rf, re); chk("R9", "zero release refused", re, 1);
        run("R7", 0, 0, 0, 0, 0, ra, rf, re);   chk("R7", "zero alloc fails", rf, 1);
        run("R7", 0, 0, 0, 200, 0, ra, rf, re); chk("R7", "too large fails", rf, 1);
        run("R7", 0, 3, 0, 141, 0, ra, rf, re); chk("R7", "table kept", ra, 115);

        // R4/R5 tie: three holes of 50 words in slots 0, 1, 2.
        do_reset();
        run("R2", 0, 0, 0, 50, 0, ra, rf, re);
        run("R2", 0, 0, 0, 10, 0, ra, rf, re);
        run("R2", 0, 0, 0, 50, 0, ra, rf, re);
        run("R2", 0, 0, 0, 10, 0, ra, rf, re);
        run("R8", 1, 0, 0, 50, 0, ra, rf, re);
        run("R8", 1, 0, 60, 50, 0, ra, rf, re);
        run("R2", 0, 0, 0, 86, 0, ra, rf, re); chk("R2", "carve slot 0", ra, 120);
        run("R5", 0, 3, 0, 50, 0, ra, rf, re); chk("R5", "tie lowest index", ra, 206);
        run("R4", 0, 2, 0, 50, 0, ra, rf, re); chk("R4", "tie lowest index", ra, 0);
        run("R8", 1, 0, 50, 10, 0, ra, rf, re);  // upper neighbour at 60
        run("R4", 0, 2, 0, 60, 0, ra, rf, re); chk("R8", "upper merge size", ra, 50);

        // R8 both-side merge, then R9 table full.
        do_reset();
        for (int i = 0; i < 4; i++) run("R2", 0, 0, 0, 8, 0, ra, rf, re);
        run("R8", 1, 0, 0, 8, 0, ra, rf, re);
        run("R8", 1, 0, 16, 8, 0, ra, rf, re);
        run("R8", 1, 0, 8, 8, 0, ra, rf, re);
        run("R4", 0, 2, 0, 24, 0, ra, rf, re); chk("R8", "both-side merge", ra, 0);
        do_reset();
        for (int i = 0; i < 64; i++) run("R2", 0, 0, 0, 4, 0, ra, rf, re);
        for (int i = 0; i < 16; i++) run("R8", 1, 0, i * 8, 4, 0, ra, rf, re);
        run("R9", 1, 0, 128, 4, 0, ra, rf, re); chk("R9", "table full refused", re, 1);
        run("R2", 0, 0, 0, 4, 0, ra, rf, re);   chk("R9", "table kept after refusal", ra, 0);

        // Pseudo-random sweep across all policies and releases.
        do_reset();
        bc = 0;
        for (int k = 0; k < 400; k++) begin
            int r, pol, n, j;
            r = rnd();
            if (bc == 0 || (bc < 64 && (r % 2) == 0)) begin
                pol = (r >> 3) % 4;
                n = 1 + ((r >> 6) % 24);
                case (pol)
                    0: run("R2", 0, pol, 0, n, (k % 7 == 0) ? 2 : 0, ra, rf, re);
                    1: run("R3", 0, pol, 0, n, 0, ra, rf, re);
                    2: run("R4", 0, pol, 0, n, 0, ra, rf, re);
                    default: run("R5", 0, pol, 0, n, 0, ra, rf, re);
                endcase
                if (rf == 0) begin
                    ba[bc] = ra; bn[bc] = n; bc++;
                end
            end else begin
                j = (r >> 4) % bc;
                run("R8", 1, (r >> 9) % 4, ba[j], bn[j], 0, ra, rf, re);
                if (re == 0) begin
                    ba[j] = ba[bc - 1]; bn[j] = bn[bc - 1]; bc--;
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule